// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block is a clocked sequencer that converts single-beat host requests into the strobe patterns an asynchronous static RAM expects. The host raises a request for one clock, together with a direction flag, an address and, for writes, the data. The controller latches these values and drives the memory address, data and active-low chip, write and output enables. It reports completion with a one-clock done pulse. Every phase length is set in whole clock cycles by configuration inputs. These cover address setup ahead of the write strobe, write strobe width, data setup, data hold, read access and the minimum total cycle.

In a write, chip enable falls first. The write strobe falls after the setup count and rises before chip enable. The write data is driven from the moment chip enable falls until the hold count has elapsed after the write strobe rises. In a read, the write strobe stays high. The output enable is held off until the access count has run from the chip-enable fall. The data is captured into a register at the end of the single output-enable clock.

A write-protect input gates the block. While it is asserted no new cycle is accepted. If it rises while a cycle is running, the strobes are withdrawn one per clock and the cycle ends with an error indication.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, the chip, write and output enables are all high (inactive), the data bus drive is off, and busy, done and error are low.
- R2: While write-protect is high and the block is idle, a request is not accepted: busy stays low and all three enables stay high.
- R3: The memory address takes the requested value when the request is accepted and does not change while busy is high.
- R4: In a write, chip enable is low and write enable high for exactly max(1, address-setup count) clocks before write enable falls; write enable is low only while chip enable is low.
- R5: In a write, write enable stays low for exactly max(1, pulse count, data-setup count) clocks, and write data is driven during the whole low time.
- R6: After write enable rises, write data stays driven with chip enable low for exactly max(1, data-hold count) clocks.
- R7: In a read, write enable never falls, chip enable is low for exactly max(1, access count) clocks before output enable falls, output enable is low for exactly one clock, and the word present on the memory data input in that clock is returned on read data and held until the next read completes.
- R8: Write enable and output enable are never low together, and the data bus is never driven while output enable is low.
- R9: Busy is high for exactly max(minimum-cycle count, natural length) clocks, where the natural length is 2 + setup + pulse + hold for a write and 4 + access for a read (each term at least 1).
- R10: Done is high for exactly one clock, in the clock after busy falls; error is low for a normal completion.
- R11: If write-protect is high in a busy clock before the release sequence, write enable is high in the next clock, output enable is high one clock later, chip enable is high one clock after that, and the cycle ends with done and error both high and read data unchanged.
- R12: A configured count of zero acts as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_i | input | 1 | Write-protect: blocks new cycles, aborts a running one |
| cfg_asetup_i | input | CNT_W | Clocks of chip enable low before write enable falls |
| cfg_pulse_i | input | CNT_W | Minimum write-enable low clocks |
| cfg_dsetup_i | input | CNT_W | Minimum clocks of data valid before write enable rises |
| cfg_dhold_i | input | CNT_W | Clocks of data drive after write enable rises |
| cfg_access_i | input | CNT_W | Clocks from chip enable low to output enable low |
| cfg_mincyc_i | input | CNT_W | Minimum busy length in clocks |
| req_i | input | 1 | Request strobe, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Last captured read word |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Set with done when the cycle was aborted |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Memory write data |
| mem_dq_oe_o | output | 1 | Drive enable for the memory data bus |
| mem_dq_i | input | DATA_W | Memory read data |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |

## Verification
The properties assume that the configuration inputs stay constant while busy is high. They also assume that write-protect is changed only between clock edges, so the state it sees at an edge is unambiguous. The stimulus changes configuration, address, data and direction only while the block is idle, and drives all inputs on the falling clock edge. Write-protect is raised mid-cycle only in directed abort cases and in an idle blocking case, and random operations run with it low.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   // Controller phases; order is not decoded anywhere
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,   // address driven, all strobes inactive
      ST_WSET,   // CE low, data driven, WE high
      ST_WPUL,   // write strobe low
      ST_WHLD,   // WE high again, data still driven, CE low
      ST_RACC,   // CE low, waiting out access time
      ST_ROE,    // OE low, data sampled at end
      ST_RREL,   // OE high, CE still low
      ST_END,    // strobes inactive, stretch to minimum cycle
      ST_AB1,    // abort: write strobe released
      ST_AB2,    // abort: output enable released
      ST_AB3     // abort: chip enable released
   } sramc_state_e;

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_cycle_meter.sv
module sramc_cycle_meter #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] min_cyc,
   output logic             met
);

   localparam int MTR_W = CNT_W + 1;
   localparam logic [MTR_W-1:0] MTR_MAX = '1;

   logic [MTR_W-1:0] elapsed_q;

   // elapsed_q equals the number of busy clocks including the current one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
      end else if (start) begin
         elapsed_q <= MTR_W'(1);
      end else if (elapsed_q != MTR_MAX) begin
         elapsed_q <= elapsed_q + 1'b1;
      end
   end

   assign met = (elapsed_q >= {1'b0, min_cyc});

endmodule

// File: rtl/sramc_rd_capture.sv
module sramc_rd_capture #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   localparam int N_LANES = (DATA_W + LANE_W - 1) / LANE_W;

   // Lane-sliced holding register, last lane may be narrower
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int LO = g * LANE_W;
      localparam int HI = ((g + 1) * LANE_W > DATA_W) ? DATA_W - 1 : (g + 1) * LANE_W - 1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[HI:LO] <= '0;
         end else if (en) begin
            q[HI:LO] <= d[HI:LO];
         end
      end
   end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sramc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_i,
   input  logic [CNT_W-1:0]  cfg_asetup_i,
   input  logic [CNT_W-1:0]  cfg_pulse_i,
   input  logic [CNT_W-1:0]  cfg_dsetup_i,
   input  logic [CNT_W-1:0]  cfg_dhold_i,
   input  logic [CNT_W-1:0]  cfg_access_i,
   input  logic [CNT_W-1:0]  cfg_mincyc_i,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe_o,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              mem_ce_n_o,
   output logic              mem_we_n_o,
   output logic              mem_oe_n_o
);

   if (ADDR_W < 1) begin : g_chk_addr
      $error("sram_cycle_ctrl: ADDR_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("sram_cycle_ctrl: DATA_W must be at least 1");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("sram_cycle_ctrl: CNT_W must be at least 2");
   end

   // Count-to-reload conversion: a phase of n clocks loads n-1, zero acts as one
   function automatic logic [CNT_W-1:0] span_m1(input logic [CNT_W-1:0] n);
      return (n == '0) ? '0 : n - 1'b1;
   endfunction

   function automatic logic ce_active(input sramc_state_e s);
      return s inside {ST_WSET, ST_WPUL, ST_WHLD, ST_RACC, ST_ROE, ST_RREL};
   endfunction

   sramc_state_e     st_q, st_d;
   logic             tmr_load, tmr_done, mtr_met, accept, cap_en;
   logic [CNT_W-1:0] tmr_val, pulse_eff;
   logic             wr_q, ab_ce_q, ab_oe_q, ab_dq_q, done_q, err_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   assign pulse_eff = (cfg_pulse_i >= cfg_dsetup_i) ? cfg_pulse_i : cfg_dsetup_i;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_i && !wp_i) begin
               accept = 1'b1;
               st_d   = ST_ADDR;
            end
         end
         ST_ADDR: begin
            tmr_load = 1'b1;
            if (wr_q) begin
               st_d    = ST_WSET;
               tmr_val = span_m1(cfg_asetup_i);
            end else begin
               st_d    = ST_RACC;
               tmr_val = span_m1(cfg_access_i);
            end
         end
         ST_WSET: begin
            if (tmr_done) begin
               st_d     = ST_WPUL;
               tmr_load = 1'b1;
               tmr_val  = span_m1(pulse_eff);
            end
         end
         ST_WPUL: begin
            if (tmr_done) begin
               st_d     = ST_WHLD;
               tmr_load = 1'b1;
               tmr_val  = span_m1(cfg_dhold_i);
            end
         end
         ST_WHLD: if (tmr_done) st_d = ST_END;
         ST_RACC: if (tmr_done) st_d = ST_ROE;
         ST_ROE:  st_d = ST_RREL;
         ST_RREL: st_d = ST_END;
         ST_END:  if (mtr_met) st_d = ST_IDLE;
         ST_AB1:  st_d = ST_AB2;
         ST_AB2:  st_d = ST_AB3;
         ST_AB3:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
      // Write-protect during any active phase diverts to the release sequence
      if (wp_i && (st_q inside {ST_ADDR, ST_WSET, ST_WPUL, ST_WHLD,
                                ST_RACC, ST_ROE, ST_RREL, ST_END})) begin
         st_d     = ST_AB1;
         tmr_load = 1'b0;
      end
   end

   assign cap_en = (st_q == ST_ROE) && (st_d == ST_RREL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         ab_ce_q <= 1'b0;
         ab_oe_q <= 1'b0;
         ab_dq_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
         err_q  <= (st_q == ST_AB3);
         if (accept) begin
            wr_q    <= wr_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
         end
         if ((st_d == ST_AB1) && (st_q != ST_AB1)) begin
            ab_ce_q <= ce_active(st_q);
            ab_oe_q <= (st_q == ST_ROE);
            ab_dq_q <= st_q inside {ST_WSET, ST_WPUL, ST_WHLD};
         end
      end
   end

   sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   sramc_cycle_meter #(.CNT_W(CNT_W)) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .min_cyc (cfg_mincyc_i),
      .met     (mtr_met)
   );

   sramc_rd_capture #(.DATA_W(DATA_W), .LANE_W(8)) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cap_en),
      .d     (mem_dq_i),
      .q     (rdata_o)
   );

   // Strobes decoded from the state register only
   always_comb begin
      mem_ce_n_o  = !(ce_active(st_q) ||
                      (((st_q == ST_AB1) || (st_q == ST_AB2)) && ab_ce_q));
      mem_we_n_o  = (st_q != ST_WPUL);
      mem_oe_n_o  = !((st_q == ST_ROE) || ((st_q == ST_AB1) && ab_oe_q));
      mem_dq_oe_o = (st_q inside {ST_WSET, ST_WPUL, ST_WHLD}) ||
                    (((st_q == ST_AB1) || (st_q == ST_AB2)) && ab_dq_q);
   end

   assign mem_addr_o = addr_q;
   assign mem_dq_o   = wdata_q;
   assign busy_o     = (st_q != ST_IDLE);
   assign done_o     = done_q;
   assign err_o      = err_q;

endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wp_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_dq_oe_o,
   input logic              mem_ce_n_o,
   input logic              mem_we_n_o,
   input logic              mem_oe_n_o
);

   a_r2_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (mem_ce_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

   a_r2_wp_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_i && !busy_o) |=> !busy_o);

   a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

   a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n_o |-> !mem_ce_n_o);

   a_r6_data_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n_o) |-> (mem_dq_oe_o && !mem_ce_n_o));

   a_r8_write_priority: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n_o |-> mem_oe_n_o);

   a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe_o |-> mem_oe_n_o);

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r11_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

endmodule

bind sram_cycle_ctrl sramc_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wp_i        (wp_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .mem_addr_o  (mem_addr_o),
   .mem_dq_oe_o (mem_dq_oe_o),
   .mem_ce_n_o  (mem_ce_n_o),
   .mem_we_n_o  (mem_we_n_o),
   .mem_oe_n_o  (mem_oe_n_o)
);

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wp = 1'b0, req = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [CW-1:0] c_as = 1, c_pw = 1, c_ds = 1, c_dh = 1, c_acc = 1, c_min = 0;
   logic [DW-1:0] rdata, dq_o, dq_i;
   logic [AW-1:0] maddr;
   logic busy, done, err, dq_oe, ce_n, we_n, oe_n;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   logic [DW-1:0] dev_mem [16] = '{default: '0};
   logic [DW-1:0] exp_mem [16] = '{default: '0};
   logic [DW-1:0] last_rd = '0;

   always #10 clk = ~clk;

   sram_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .wp_i(wp),
      .cfg_asetup_i(c_as), .cfg_pulse_i(c_pw), .cfg_dsetup_i(c_ds),
      .cfg_dhold_i(c_dh), .cfg_access_i(c_acc), .cfg_mincyc_i(c_min),
      .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .busy_o(busy), .done_o(done), .err_o(err),
      .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i),
      .mem_ce_n_o(ce_n), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n)
   );

   // Behavioural asynchronous memory: latches during the write window
   always @(negedge clk) if (!ce_n && !we_n) dev_mem[maddr[3:0]] <= dq_o;
   assign dq_i = (!ce_n && we_n && !oe_n) ? dev_mem[maddr[3:0]] : 16'hBAD0;

   function automatic int c1(input int v);
      return (v == 0) ? 1 : v;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
   function automatic int exp_busy(input bit w);
      int nat;
      if (w) nat = 2 + c1(int'(c_as)) + imax(c1(int'(c_pw)), c1(int'(c_ds))) + c1(int'(c_dh));
      else   nat = 4 + c1(int'(c_acc));
      return imax(nat, int'(c_min));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic run_op(input bit w, input logic [3:0] a, input logic [DW-1:0] d);
      int busy_n = 0, pre = 0, we_lo = 0, oe_lo = 0, hold = 0, ovl = 0, achg = 0;
      bit we_seen = 0, oe_seen = 0, got = 0;
      @(negedge clk);
      req = 1'b1; wr = w; addr = {12'h0, a}; wdata = d;
      @(negedge clk);
      req = 1'b0;
      chk(maddr == {12'h0, a}, "R3 address taken", int'(maddr), int'(a));
      for (int k = 0; k < 600; k++) begin
         if (done) begin got = 1; break; end
         if (busy) busy_n++;
         if (maddr != {12'h0, a}) achg++;
         if (!ce_n && we_n && oe_n && !we_seen && !oe_seen) pre++;
         if (!we_n) begin we_lo++; we_seen = 1; end
         if (!oe_n) begin oe_lo++; oe_seen = 1; end
         if (we_seen && we_n && dq_oe && !ce_n) hold++;
         if (!we_n && !dq_oe) ovl++;
         if ((!we_n && !oe_n) || (dq_oe && !oe_n)) ovl++;
         @(negedge clk);
      end
      chk(got, "R10 done seen", int'(got), 1);
      chk(!err && !busy, "R10 clean completion", int'(err), 0);
      chk(busy_n == exp_busy(w), "R9 busy length", busy_n, exp_busy(w));
      chk(achg == 0, "R3 address stable", achg, 0);
      chk(ovl == 0, "R8 strobe overlap or bus clash", ovl, 0);
      if (w) begin
         exp_mem[a] = d;
         chk(pre == c1(int'(c_as)), "R4 setup before WE", pre, c1(int'(c_as)));
         chk(we_lo == imax(c1(int'(c_pw)), c1(int'(c_ds))), "R5 WE width", we_lo,
             imax(c1(int'(c_pw)), c1(int'(c_ds))));
         chk(hold == c1(int'(c_dh)), "R6 data hold", hold, c1(int'(c_dh)));
         chk(rdata == last_rd, "R7 read data held over write", int'(rdata), int'(last_rd));
      end else begin
         chk(we_lo == 0, "R7 no WE in read", we_lo, 0);
         chk(pre == c1(int'(c_acc)), "R7 access before OE", pre, c1(int'(c_acc)));
         chk(oe_lo == 1, "R7 OE width", oe_lo, 1);
         chk(rdata == exp_mem[a], "R7 read data", int'(rdata), int'(exp_mem[a]));
         last_rd = exp_mem[a];
      end
      @(negedge clk);
      chk(!done, "R10 done one clock", int'(done), 0);
   endtask

   // Abort at the third busy clock (write: during WE low with as=1)
   task automatic run_abort(input bit w, input logic [3:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req = 1'b1; wr = w; addr = {12'h0, a}; wdata = d;
      @(negedge clk); req = 1'b0;           // ADDR
      @(negedge clk);                       // WSET / RACC
      @(negedge clk);                       // WPUL / RACC
      if (w) chk(!we_n, "R11 WE low before abort", int'(we_n), 0);
      wp = 1'b1;
      @(negedge clk);
      chk(we_n && !ce_n, "R11 WE released first", int'({we_n, ce_n}), 2);
      @(negedge clk);
      chk(we_n && oe_n && !ce_n, "R11 OE released, CE held", int'({oe_n, ce_n}), 2);
      @(negedge clk);
      chk(ce_n && we_n && oe_n && !dq_oe, "R11 CE released last", int'(ce_n), 1);
      @(negedge clk);
      chk(done && err && !busy, "R11 done with error", int'({done, err}), 3);
      chk(rdata == last_rd, "R11 read data unchanged", int'(rdata), int'(last_rd));
      if (w) exp_mem[a] = d;
      wp = 1'b0;
      @(negedge clk);
      chk(!done && !err, "R10 abort done one clock", int'({done, err}), 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk(ce_n && we_n && oe_n, "R1 strobes high in reset", int'({ce_n, we_n, oe_n}), 7);
      chk(!busy && !done && !err && !dq_oe, "R1 status low in reset",
          int'({busy, done, err, dq_oe}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ce_n && we_n && oe_n && !busy, "R1 idle after reset", int'(busy), 0);

      // R2: requests refused under write-protect
      wp = 1'b1; req = 1'b1; wr = 1'b1; addr = 16'h3; wdata = 16'hFFFF;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(!busy && ce_n && we_n && oe_n, "R2 no cycle under protect", int'(busy), 0);
      end
      req = 1'b0; wp = 1'b0;
      chk(dev_mem[3] == 16'h0, "R2 memory untouched", int'(dev_mem[3]), 0);

      // R12: all counts zero
      c_as = 0; c_pw = 0; c_ds = 0; c_dh = 0; c_acc = 0; c_min = 0;
      run_op(1'b1, 4'h1, 16'hA5A5);
      run_op(1'b0, 4'h1, 16'h0);

      // R5: data setup dominates pulse; R9: minimum cycle dominates
      c_as = 2; c_pw = 1; c_ds = 4; c_dh = 3; c_acc = 3; c_min = 30;
      run_op(1'b1, 4'h7, 16'h1234);
      run_op(1'b0, 4'h7, 16'h0);
      c_min = 0;

      // R11: aborts
      c_as = 1; c_pw = 8; c_ds = 1; c_dh = 1; c_acc = 6;
      run_abort(1'b1, 4'h9, 16'h5678);
      run_abort(1'b0, 4'h9, 16'h0);

      // Random operations
      for (int i = 0; i < 60; i++) begin
         c_as  = CW'($urandom_range(0, 5));
         c_pw  = CW'($urandom_range(0, 5));
         c_ds  = CW'($urandom_range(0, 5));
         c_dh  = CW'($urandom_range(0, 5));
         c_acc = CW'($urandom_range(0, 5));
         c_min = CW'($urandom_range(0, 20));
         run_op(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                16'($urandom_range(0, 65535)));
      end
      finish_run();
   end

endmodule